// File: doc/BRIEF.md
# Flash Range Signature Engine

This block computes a 128-bit signature over a contiguous range of 128-bit flash words, typically to confirm that programmed contents match a value computed elsewhere. Software writes a first word index, then writes the last word index together with a go bit. From then on the engine steps through the range without help. For each word it holds the flash read port for a programmable number of clocks and then folds the word into a multiple-input signature register.

While a run is in progress, the engine owns the flash read port. A host read that arrives during a run is held off with a wait signal until the run ends. When the engine is idle, host reads go straight to the flash and the data comes back on the host read port. A small register port holds the access-time setting, the two word indices, the status flags and the four 32-bit slices of the signature.

Top module: `sigflash_ctrl`

## Requirements
- R1: After reset, the registers read as follows: config = 2, first index = 0, last index = 0, status = 0, and all four signature slices = 0.
- R2: The register offsets are 0 config (access field in bits [1:0]), 1 first index (bits [16:0]), 2 last index (bits [16:0], go in bit 31) and 3 status (bit 0 busy, bit 1 done). Offsets 4 to 7 hold the signature slices, least-significant 32 bits at offset 4. Unused bits read 0, and the go bit always reads 0.
- R3: A write to offset 2 with bit 31 set while idle starts a run. The signature clears to zero, done clears and busy reads 1 in the next cycle.
- R4: A run processes the words from the first index up to and including the last index, in increasing order. If the last index is below the first, only the first word is processed.
- R5: The flash port presents each word for (access + 1) clocks, so busy lasts exactly words × (access + 1) cycles.
- R6: Each word w updates the signature as s' = {s[126:0], s[127]} ^ w ^ (s[127] ? 128'h87 : 0).
- R7: Done is set when the last word has been folded, and it stays set until the next accepted start.
- R8: Every register write made while busy is ignored, including a second start.
- R9: A write of 3 (reserved) to the access field leaves that field unchanged. Values 0, 1 and 2 are stored.
- R10: A host read request raises host_wait while busy. When idle, there is no wait and host_rdata equals the flash word at host_addr.
- R11: The signature slices read as 0 while busy and read the final value once idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (combinational) |
| fl_en | output | 1 | Flash read enable |
| fl_addr | output | 17 | Flash word index |
| fl_rdata | input | 128 | Flash read data |
| host_req | input | 1 | Host flash read request |
| host_addr | input | 17 | Host word index |
| host_wait | output | 1 | Host read held off |
| host_rdata | output | 128 | Host read data |

## Verification
The bench uses the default parameters: a 17-bit word index, 128-bit words, a 2-bit access field with reset value 2, and 32-bit registers. The behavioural flash answers from a 64-word image taken from the low index bits. With these settings the bench runs all three legal access lengths, the reserved encoding, single-word and reversed ranges, and word patterns that set the top signature bit so the feedback term is used. Writes made in the middle of a run check that the walker, the configuration and the result stay undisturbed.

// File: rtl/sigflash_pkg.sv
package sigflash_pkg;

    localparam int REG_AW = 3;
    localparam int GO_BIT = 31;
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;

    typedef enum logic [REG_AW-1:0] {
        RA_CFG   = 3'd0,
        RA_FIRST = 3'd1,
        RA_LAST  = 3'd2,
        RA_STAT  = 3'd3,
        RA_SIG0  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/sigflash_regs.sv
module sigflash_regs
    import sigflash_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 128,
    parameter int REG_W   = 32,
    parameter int ACC_W   = 2,
    parameter int ACC_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] sig,
    output logic [ACC_W-1:0]  acc,
    output logic [ADDR_W-1:0] first_idx,
    output logic [ADDR_W-1:0] last_nxt,
    output logic              go,
    output logic [REG_W-1:0]  rdata
);

    localparam int NSIG = DATA_W / REG_W;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ok;
    logic [REG_W-1:0] sig_word [NSIG];

    assign wr_ok = wr && !busy;

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            case (reg_sel_e'(addr))
                RA_CFG: begin
                    if (wdata[ACC_W-1:0] != {ACC_W{1'b1}}) begin
                        r_d.acc = wdata[ACC_W-1:0];
                    end
                end
                RA_FIRST: r_d.first = wdata[ADDR_W-1:0];
                RA_LAST:  r_d.last  = wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.acc   <= ACC_W'(ACC_RST);
            r_q.first <= '0;
            r_q.last  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign go        = wr_ok && (addr == REG_AW'(RA_LAST)) && wdata[GO_BIT];
    assign acc       = r_q.acc;
    assign first_idx = r_q.first;
    assign last_nxt  = r_d.last;

    for (genvar g = 0; g < NSIG; g++) begin : g_slice
        assign sig_word[g] = busy ? '0 : sig[g*REG_W +: REG_W];
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            RA_CFG:   rdata[ACC_W-1:0]  = r_q.acc;
            RA_FIRST: rdata[ADDR_W-1:0] = r_q.first;
            RA_LAST:  rdata[ADDR_W-1:0] = r_q.last;
            RA_STAT: begin
                rdata[ST_BUSY] = busy;
                rdata[ST_DONE] = done;
            end
            default: begin
                for (int i = 0; i < NSIG; i++) begin
                    if (addr == REG_AW'(int'(RA_SIG0) + i)) begin
                        rdata = sig_word[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/sigflash_walker.sv
module sigflash_walker #(
    parameter int ADDR_W = 17,
    parameter int ACC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] first_idx,
    input  logic [ADDR_W-1:0] last_idx,
    input  logic [ACC_W-1:0]  acc,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              busy,
    output logic              done,
    output logic              fold_en,
    output logic              fl_en,
    output logic [ADDR_W-1:0] fl_addr
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] last;
        logic [ACC_W-1:0]  cnt;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d     = w_q;
        fold_en = 1'b0;
        if (!w_q.busy) begin
            if (go) begin
                w_d.busy = 1'b1;
                w_d.done = 1'b0;
                w_d.addr = first_idx;
                w_d.last = (last_idx < first_idx) ? first_idx : last_idx;
                w_d.cnt  = acc;
            end
        end else if (w_q.cnt == '0) begin
            fold_en = 1'b1;
            if (w_q.addr == w_q.last) begin
                w_d.busy = 1'b0;
                w_d.done = 1'b1;
            end else begin
                w_d.addr = w_q.addr + 1'b1;
                w_d.cnt  = acc;
            end
        end else begin
            w_d.cnt = w_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign busy    = w_q.busy;
    assign done    = w_q.done;
    assign fl_en   = w_q.busy ? 1'b1 : host_req;
    assign fl_addr = w_q.busy ? w_q.addr : host_addr;

endmodule

// File: rtl/sigflash_misr.sv
module sigflash_misr #(
    parameter int          DATA_W = 128,
    parameter logic [DATA_W-1:0] POLY = 128'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fold_en,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] sig
);

    typedef struct packed {
        logic [DATA_W-1:0] sig;
    } misr_t;

    misr_t m_d, m_q;

    function automatic logic [DATA_W-1:0] fold(input logic [DATA_W-1:0] s,
                                               input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] rot;
        rot = {s[DATA_W-2:0], s[DATA_W-1]};
        return rot ^ w ^ (s[DATA_W-1] ? POLY : '0);
    endfunction

    always_comb begin
        m_d = m_q;
        if (clr) begin
            m_d.sig = '0;
        end else if (fold_en) begin
            m_d.sig = fold(m_q.sig, word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign sig = m_q.sig;

endmodule

// File: rtl/sigflash_ctrl.sv
module sigflash_ctrl
    import sigflash_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 128,
    parameter int REG_W   = 32,
    parameter int ACC_W   = 2,
    parameter int ACC_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              fl_en,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_rdata,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_wait,
    output logic [DATA_W-1:0] host_rdata
);

    logic [ACC_W-1:0]  acc;
    logic [ADDR_W-1:0] first_idx;
    logic [ADDR_W-1:0] last_nxt;
    logic              go;
    logic              busy;
    logic              done;
    logic              fold_en;
    logic [DATA_W-1:0] sig;

    sigflash_regs #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .REG_W (REG_W),
        .ACC_W  (ACC_W),  .ACC_RST(ACC_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (busy),
        .done     (done),
        .sig      (sig),
        .acc      (acc),
        .first_idx(first_idx),
        .last_nxt (last_nxt),
        .go       (go),
        .rdata    (reg_rdata)
    );

    sigflash_walker #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .first_idx(first_idx),
        .last_idx (last_nxt),
        .acc      (acc),
        .host_req (host_req),
        .host_addr(host_addr),
        .busy     (busy),
        .done     (done),
        .fold_en  (fold_en),
        .fl_en    (fl_en),
        .fl_addr  (fl_addr)
    );

    sigflash_misr #(.DATA_W(DATA_W)) u_misr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .fold_en(fold_en),
        .word   (fl_rdata),
        .sig    (sig)
    );

    assign host_wait  = host_req && busy;
    assign host_rdata = fl_rdata;

endmodule

// File: rtl/sigflash_chk.sv
module sigflash_chk #(
    parameter int ADDR_W = 17,
    parameter int ACC_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              go,
    input logic [ACC_W-1:0]  acc,
    input logic              fl_en,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              host_req,
    input logic              host_wait
);

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && !done));

    // R7
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10
    host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && busy) |-> host_wait);

    // R4
    walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (fl_en &&
            (fl_addr == $past(fl_addr) || fl_addr == $past(fl_addr) + 1'b1)));

    // R9
    acc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc != {ACC_W{1'b1}});

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(acc));

endmodule

bind sigflash_ctrl sigflash_chk #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .go       (go),
    .acc      (acc),
    .fl_en    (fl_en),
    .fl_addr  (fl_addr),
    .host_req (host_req),
    .host_wait(host_wait)
);

// File: tb/sim_sigflash_ctrl.sv
module sim_sigflash_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         fl_en;
    logic [16:0]  fl_addr;
    logic [127:0] fl_rdata;
    logic         host_req = 1'b0;
    logic [16:0]  host_addr = '0;
    logic         host_wait;
    logic [127:0] host_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    logic [127:0] exp_q [$];

    always #4 clk = ~clk;

    function automatic logic [127:0] img(input logic [16:0] a);
        logic [31:0] i;
        i = {26'd0, a[5:0]};
        return {i * 32'h9E37_79B9, ~(i * 32'h7F4A_7C15),
                i ^ 32'hA5A5_5A5A, 32'h0001_0000 + i};
    endfunction

    function automatic logic [127:0] fold_m(input logic [127:0] s, input logic [127:0] w);
        return {s[126:0], s[127]} ^ w ^ (s[127] ? 128'h87 : 128'h0);
    endfunction

    assign fl_rdata = img(fl_addr);

    sigflash_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_en(fl_en),
        .fl_addr(fl_addr), .fl_rdata(fl_rdata), .host_req(host_req),
        .host_addr(host_addr), .host_wait(host_wait), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic read_sig(output logic [127:0] s);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rd(3'(4 + k), v);
            s[32*k +: 32] = v;
        end
    endtask

    // driver: computes expected signature and pushes it to the scoreboard queue
    task automatic push_exp(input int f, input int l);
        logic [127:0] s;
        int e;
        s = '0;
        e = (l < f) ? f : l;
        for (int a = f; a <= e; a++) s = fold_m(s, img(17'(a)));
        exp_q.push_back(s);
    endtask

    // monitor side: pop expected and compare against read-back result
    task automatic score(input string req);
        logic [127:0] s;
        logic [127:0] e;
        read_sig(s);
        e = exp_q.pop_front();
        chk(req, s, e);
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] v;
        cyc = 0;
        forever begin
            rd(3'd3, v);
            if (!v[0]) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run(input int f, input int l, input int acc, input string req);
        logic [31:0] v;
        int cyc;
        int n;
        wr(3'd0, 32'(acc));
        wr(3'd1, 32'(f));
        push_exp(f, l);
        wr(3'd2, 32'h8000_0000 | 32'(l));
        rd(3'd3, v);
        chk("R3 R7 busy set done cleared", {96'd0, v}, 128'd1);
        wait_idle(cyc);
        n = (l < f) ? 1 : (l - f + 1);
        chk({"R5 R4 busy length ", req}, 128'(cyc), 128'(n * (acc + 1)));
        rd(3'd3, v);
        chk("R7 done after run", {96'd0, v}, 128'd2);
        score({"R6 signature ", req});
    endtask

    initial begin
        logic [31:0] v;
        logic [127:0] s;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(3'd0, v); chk("R1 cfg reset", {96'd0, v}, 128'd2);
        rd(3'd1, v); chk("R1 first reset", {96'd0, v}, 128'd0);
        rd(3'd2, v); chk("R1 last reset", {96'd0, v}, 128'd0);
        rd(3'd3, v); chk("R1 status reset", {96'd0, v}, 128'd0);
        read_sig(s); chk("R1 signature reset", s, 128'd0);

        // R2 field widths and readback
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R2 first width", {96'd0, v}, 128'h1FFFF);
        wr(3'd2, 32'h7FFF_FFFF);
        rd(3'd2, v); chk("R2 last width", {96'd0, v}, 128'h1FFFF);
        rd(3'd3, v); chk("R2 no go no start", {96'd0, v}, 128'd0);

        // R9 reserved access code
        wr(3'd0, 32'd1);
        wr(3'd0, 32'd3);
        rd(3'd0, v); chk("R9 reserved ignored", {96'd0, v}, 128'd1);

        // R4 R5 R6 runs at several access lengths and ranges
        run(3, 6, 2, "acc2 range");
        rd(3'd2, v); chk("R2 go reads zero", {96'd0, v}, 128'd6);
        run(10, 10, 0, "single word");
        run(20, 15, 1, "reversed range");
        run(0, 12, 1, "acc1 range");
        run(40, 63, 0, "acc0 long");

        // R8 R10 R11 activity during a run
        wr(3'd0, 32'd2);
        wr(3'd1, 32'd30);
        push_exp(30, 39);
        wr(3'd2, 32'h8000_0000 | 32'd39);
        host_req = 1'b1; host_addr = 17'd5;
        #1;
        chk("R10 host wait while busy", {127'd0, host_wait}, 128'd1);
        rd(3'd4, v); chk("R11 slice zero while busy", {96'd0, v}, 128'd0);
        rd(3'd7, v); chk("R11 top slice zero while busy", {96'd0, v}, 128'd0);
        wr(3'd1, 32'd7);
        wr(3'd2, 32'h8000_0000 | 32'd50);
        wr(3'd0, 32'd0);
        wait_idle(cyc);
        rd(3'd1, v); chk("R8 first unchanged", {96'd0, v}, 128'd30);
        rd(3'd2, v); chk("R8 last unchanged", {96'd0, v}, 128'd39);
        rd(3'd0, v); chk("R8 cfg unchanged", {96'd0, v}, 128'd2);
        score("R8 R11 signature after busy writes");
        #1;
        chk("R10 no wait when idle", {127'd0, host_wait}, 128'd0);
        chk("R10 host data", host_rdata, img(17'd5));
        host_addr = 17'd33;
        #1;
        chk("R10 host data second", host_rdata, img(17'd33));
        host_req = 1'b0;

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule